// File: doc/BRIEF.md
# Frequency Level Transition Sequencer

The block moves a processor clock domain from one of five performance levels to another. Levels are numbered 0 (fastest, 1200 MHz nominal) through 4 (slowest, 200 MHz nominal); 1000, 800 and 500 MHz lie between them. A request gives the current level and the target level. The sequencer then works through a register-style port toward the external clock hardware: the main PLL setting word, the PLL lock-time register, the core clock source selector, and two divider configuration registers. After each update it polls the matching status register before it goes on.

Per-level constants are computed inside the block. These are the PLL multiplier, predivider and post-scaler, and the divider settings. The order of the updates depends on the direction of the change. A full PLL relock with the core temporarily moved to the alternate fixed PLL happens only when the multiplier or predivider actually changes. Otherwise only the post-scaler field is rewritten. Each status poll is bounded by a programmable cycle limit. When the limit runs out, the block stops in a sticky error state.

Top module: `freq_step_seq`

## Requirements
- R1: Per level 0..4 the target PLL fields (M at bits 25:16, P at bits 13:8, S at bits 2:0) are (150,3,1), (250,6,1), (200,6,1), (250,6,2), (200,6,3). The divider-1 upper field values are 5, 4, 3, 3, 3, and the lower field is 0 at every level.
- R2: When the target index is lower than the current one, the divider registers are updated first and the PLL second.
- R3: When the target index is higher, the PLL is updated first and the divider registers second.
- R4: If the M and P fields of the two levels are equal, the PLL step is only a read of address 1 followed by a write that replaces bits 2:0 and keeps all other bits. No selector or lock-time write occurs.
- R5: A full PLL change writes 2 to address 2 and polls address 3 until bits 2:0 equal 2. It then writes the lock-time parameter to address 0, reads address 1, and writes the new fields there. It polls address 1 until bit 29 (locked) is 1, writes 1 to address 2, and polls address 3 until bits 2:0 equal 1.
- R6: Divider register 0 (address 4) is written whole. Its seven 3-bit fields sit at bit 4k for k=0..6: core, core-M0, core-M1, peripheral, trace bus, debug pclk, PLL-out. The values are {0,3,7,3,4,1,7} for levels 0 and 1, {0,3,7,3,3,1,7} for levels 2 and 3, and {0,1,3,1,3,1,0} for level 4. Address 5 is then polled until bits 0x0111_1111 are all clear.
- R7: Divider register 1 (address 6) is read, and bits 6:4 and 2:0 are replaced with all other bits kept. Address 7 is then polled until bits 0x11 are clear.
- R8: The full PLL write clears only mask 0x03FF_3F07 of the word read back and keeps every other bit.
- R9: A request with equal current and target indices raises done in the cycle after acceptance, never raises busy, and makes no register write.
- R10: Busy rises in the cycle after a changing request is accepted and stays high until the last poll succeeds. Done then pulses for exactly one cycle with busy low. Requests arriving while busy are ignored.
- R11: If a poll stays unsatisfied for more than the timeout input's number of cycles, the block enters an error state. Error stays high until reset, with busy low and no further register access.
- R12: A request with either index above 4 is ignored: no busy, no done, no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Transition request, sampled while idle |
| old_lvl_i | input | 3 | Current level index |
| new_lvl_i | input | 3 | Target level index |
| timeout_i | input | 16 | Poll timeout limit in cycles |
| busy_o | output | 1 | Transition in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky poll timeout error |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe; reg_rdata_i is sampled in the same cycle |
| reg_addr_o | output | 3 | Register address (0 lock time, 1 PLL word, 2 selector, 3 selector status, 4 divider 0, 5 divider 0 status, 6 divider 1, 7 divider 1 status) |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, combinational to the address |

## Verification
Busy is due one cycle after the accepting edge. For equal indices, done is due in that same cycle. Each write is due one cycle after the previous step, or after the cycle in which its poll was satisfied. Done follows one cycle after the last satisfied poll. The bench drives requests and samples outputs on falling edges, so each of these results is read exactly one edge after its cause. Write order and data are compared item by item against an expected queue, at the falling edge of the very cycle the strobe is high. The timeout error is checked for stickiness and silence over a long window after it appears, not at an exact cycle.

// File: rtl/freq_step_pkg.sv
package freq_step_pkg;

    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 5;
    localparam int WORD_W  = 32;
    localparam int DIV0_FIELDS = 7;

    localparam logic [WORD_W-1:0] PLL_PMS_MASK = 32'h03FF_3F07;
    localparam logic [WORD_W-1:0] PLL_S_MASK   = 32'h0000_0007;
    localparam logic [WORD_W-1:0] DIV0_BUSY    = 32'h0111_1111;
    localparam logic [WORD_W-1:0] DIV1_MASK    = 32'h0000_0077;
    localparam logic [WORD_W-1:0] DIV1_BUSY    = 32'h0000_0011;
    localparam int                LOCKED_BIT   = 29;

    typedef enum logic [2:0] {
        A_LOCKTIME = 3'd0,
        A_PLLWORD  = 3'd1,
        A_SRCSEL   = 3'd2,
        A_SRCSTAT  = 3'd3,
        A_DIV0     = 3'd4,
        A_DIV0STAT = 3'd5,
        A_DIV1     = 3'd6,
        A_DIV1STAT = 3'd7
    } reg_addr_e;

    typedef enum logic [4:0] {
        S_IDLE, S_PLAN,
        S_DIV0_WR, S_DIV0_WAIT, S_DIV1_RD, S_DIV1_WR, S_DIV1_WAIT,
        S_ALT_WR, S_ALT_WAIT, S_LOCK_WR, S_PLL_RD, S_PLL_WR, S_LOCK_WAIT,
        S_MAIN_WR, S_MAIN_WAIT, S_SPLL_RD, S_SPLL_WR,
        S_DONE, S_ERR
    } seq_state_e;

    typedef struct packed {
        seq_state_e         st;
        logic [LVL_W-1:0]   old_lvl;
        logic [LVL_W-1:0]   new_lvl;
        logic               div_done;
        logic               pll_done;
        logic [WORD_W-1:0]  data;
    } seq_t;

    function automatic logic [WORD_W-1:0] level_pll_word(input logic [LVL_W-1:0] lvl);
        logic [9:0] m;
        logic [5:0] p;
        logic [2:0] s;
        case (lvl)
            3'd0:    begin m = 10'd150; p = 6'd3; s = 3'd1; end
            3'd1:    begin m = 10'd250; p = 6'd6; s = 3'd1; end
            3'd2:    begin m = 10'd200; p = 6'd6; s = 3'd1; end
            3'd3:    begin m = 10'd250; p = 6'd6; s = 3'd2; end
            default: begin m = 10'd200; p = 6'd6; s = 3'd3; end
        endcase
        return {6'd0, m, 2'd0, p, 5'd0, s};
    endfunction

    function automatic logic [WORD_W-1:0] level_div0_word(input logic [LVL_W-1:0] lvl);
        logic [DIV0_FIELDS-1:0][2:0] f;
        logic [WORD_W-1:0]           w;
        case (lvl)
            3'd0, 3'd1: f = {3'd7, 3'd1, 3'd4, 3'd3, 3'd7, 3'd3, 3'd0};
            3'd2, 3'd3: f = {3'd7, 3'd1, 3'd3, 3'd3, 3'd7, 3'd3, 3'd0};
            default:    f = {3'd0, 3'd1, 3'd3, 3'd1, 3'd3, 3'd1, 3'd0};
        endcase
        w = '0;
        for (int k = 0; k < DIV0_FIELDS; k++) begin
            w[4*k +: 3] = f[k];
        end
        return w;
    endfunction

    function automatic logic [2:0] level_div1_hi(input logic [LVL_W-1:0] lvl);
        case (lvl)
            3'd0:    return 3'd5;
            3'd1:    return 3'd4;
            default: return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/freq_level_table.sv
module freq_level_table
    import freq_step_pkg::*;
(
    input  logic [LVL_W-1:0]  lvl_i,
    output logic [WORD_W-1:0] pll_word_o,
    output logic [WORD_W-1:0] div0_word_o,
    output logic [2:0]        div1_hi_o,
    output logic [2:0]        div1_lo_o
);

    always_comb begin
        pll_word_o  = level_pll_word(lvl_i);
        div0_word_o = level_div0_word(lvl_i);
        div1_hi_o   = level_div1_hi(lvl_i);
        div1_lo_o   = 3'd0;
    end

endmodule

// File: rtl/freq_wait_timer.sv
module freq_wait_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             ok_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             expired_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (active_i && !ok_i) begin
            cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
        expired_o = active_i && !ok_i && (cnt_q >= limit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/freq_step_seq.sv
module freq_step_seq
    import freq_step_pkg::*;
#(
    parameter int                TMO_W     = 16,
    parameter logic [WORD_W-1:0] LOCK_TIME = 32'h0000_02E8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [LVL_W-1:0]  old_lvl_i,
    input  logic [LVL_W-1:0]  new_lvl_i,
    input  logic [TMO_W-1:0]  timeout_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [2:0]        reg_addr_o,
    output logic [WORD_W-1:0] reg_wdata_o,
    input  logic [WORD_W-1:0] reg_rdata_i
);

    localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LVL - 1);

    seq_t q, d;

    // index 0: current level, index 1: target level
    logic [1:0][WORD_W-1:0] tbl_pll;
    logic [1:0][WORD_W-1:0] tbl_div0;
    logic [1:0][2:0]        tbl_d1hi;
    logic [1:0][2:0]        tbl_d1lo;

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_tbl
            freq_level_table u_tbl (
                .lvl_i       ((g == 0) ? q.old_lvl : q.new_lvl),
                .pll_word_o  (tbl_pll[g]),
                .div0_word_o (tbl_div0[g]),
                .div1_hi_o   (tbl_d1hi[g]),
                .div1_lo_o   (tbl_d1lo[g])
            );
        end
    endgenerate

    logic wait_act, wait_ok, expired;

    always_comb begin
        wait_act = 1'b0;
        wait_ok  = 1'b0;
        case (q.st)
            S_DIV0_WAIT: begin wait_act = 1'b1; wait_ok = (reg_rdata_i & DIV0_BUSY) == '0; end
            S_DIV1_WAIT: begin wait_act = 1'b1; wait_ok = (reg_rdata_i & DIV1_BUSY) == '0; end
            S_ALT_WAIT:  begin wait_act = 1'b1; wait_ok = reg_rdata_i[2:0] == 3'd2; end
            S_MAIN_WAIT: begin wait_act = 1'b1; wait_ok = reg_rdata_i[2:0] == 3'd1; end
            S_LOCK_WAIT: begin wait_act = 1'b1; wait_ok = reg_rdata_i[LOCKED_BIT]; end
            default:     ;
        endcase
    end

    freq_wait_timer #(.CNT_W(TMO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (wait_act),
        .ok_i      (wait_ok),
        .limit_i   (timeout_i),
        .expired_o (expired)
    );

    logic       relock;
    seq_state_e pll_entry;
    seq_state_e pll_exit;
    seq_state_e div_exit;
    reg_addr_e  addr;

    always_comb begin
        d           = q;
        reg_wr_o    = 1'b0;
        reg_rd_o    = 1'b0;
        addr        = A_LOCKTIME;
        reg_wdata_o = '0;
        relock      = tbl_pll[0][25:8] != tbl_pll[1][25:8];
        pll_entry   = relock ? S_ALT_WR : S_SPLL_RD;
        pll_exit    = q.div_done ? S_DONE : S_DIV0_WR;
        div_exit    = q.pll_done ? S_DONE : pll_entry;

        case (q.st)
            S_IDLE: begin
                if (req_i && (old_lvl_i <= MAX_LVL) && (new_lvl_i <= MAX_LVL)) begin
                    d.old_lvl  = old_lvl_i;
                    d.new_lvl  = new_lvl_i;
                    d.div_done = 1'b0;
                    d.pll_done = 1'b0;
                    d.st       = (old_lvl_i == new_lvl_i) ? S_DONE : S_PLAN;
                end
            end
            S_PLAN: d.st = (q.new_lvl < q.old_lvl) ? S_DIV0_WR : pll_entry;
            // divider chain
            S_DIV0_WR: begin
                reg_wr_o    = 1'b1;
                addr        = A_DIV0;
                reg_wdata_o = tbl_div0[1];
                d.st        = S_DIV0_WAIT;
            end
            S_DIV0_WAIT: begin
                reg_rd_o = 1'b1;
                addr     = A_DIV0STAT;
                if (wait_ok)      d.st = S_DIV1_RD;
                else if (expired) d.st = S_ERR;
            end
            S_DIV1_RD: begin
                reg_rd_o = 1'b1;
                addr     = A_DIV1;
                d.data   = reg_rdata_i;
                d.st     = S_DIV1_WR;
            end
            S_DIV1_WR: begin
                reg_wr_o    = 1'b1;
                addr        = A_DIV1;
                reg_wdata_o = (q.data & ~DIV1_MASK) |
                              {25'd0, tbl_d1hi[1], 1'b0, tbl_d1lo[1]};
                d.st        = S_DIV1_WAIT;
            end
            S_DIV1_WAIT: begin
                reg_rd_o = 1'b1;
                addr     = A_DIV1STAT;
                if (wait_ok) begin
                    d.div_done = 1'b1;
                    d.st       = div_exit;
                end else if (expired) begin
                    d.st = S_ERR;
                end
            end
            // full PLL change
            S_ALT_WR: begin
                reg_wr_o    = 1'b1;
                addr        = A_SRCSEL;
                reg_wdata_o = 32'd2;
                d.st        = S_ALT_WAIT;
            end
            S_ALT_WAIT: begin
                reg_rd_o = 1'b1;
                addr     = A_SRCSTAT;
                if (wait_ok)      d.st = S_LOCK_WR;
                else if (expired) d.st = S_ERR;
            end
            S_LOCK_WR: begin
                reg_wr_o    = 1'b1;
                addr        = A_LOCKTIME;
                reg_wdata_o = LOCK_TIME;
                d.st        = S_PLL_RD;
            end
            S_PLL_RD: begin
                reg_rd_o = 1'b1;
                addr     = A_PLLWORD;
                d.data   = reg_rdata_i;
                d.st     = S_PLL_WR;
            end
            S_PLL_WR: begin
                reg_wr_o    = 1'b1;
                addr        = A_PLLWORD;
                reg_wdata_o = (q.data & ~PLL_PMS_MASK) | tbl_pll[1];
                d.st        = S_LOCK_WAIT;
            end
            S_LOCK_WAIT: begin
                reg_rd_o = 1'b1;
                addr     = A_PLLWORD;
                if (wait_ok)      d.st = S_MAIN_WR;
                else if (expired) d.st = S_ERR;
            end
            S_MAIN_WR: begin
                reg_wr_o    = 1'b1;
                addr        = A_SRCSEL;
                reg_wdata_o = 32'd1;
                d.st        = S_MAIN_WAIT;
            end
            S_MAIN_WAIT: begin
                reg_rd_o = 1'b1;
                addr     = A_SRCSTAT;
                if (wait_ok) begin
                    d.pll_done = 1'b1;
                    d.st       = pll_exit;
                end else if (expired) begin
                    d.st = S_ERR;
                end
            end
            // post-scaler only
            S_SPLL_RD: begin
                reg_rd_o = 1'b1;
                addr     = A_PLLWORD;
                d.data   = reg_rdata_i;
                d.st     = S_SPLL_WR;
            end
            S_SPLL_WR: begin
                reg_wr_o    = 1'b1;
                addr        = A_PLLWORD;
                reg_wdata_o = (q.data & ~PLL_S_MASK) | (tbl_pll[1] & PLL_S_MASK);
                d.pll_done  = 1'b1;
                d.st        = pll_exit;
            end
            S_DONE:  d.st = S_IDLE;
            S_ERR:   d.st = S_ERR;
            default: d.st = S_IDLE;
        endcase

        reg_addr_o = addr;
        busy_o     = !(q.st inside {S_IDLE, S_DONE, S_ERR});
        done_o     = q.st == S_DONE;
        err_o      = q.st == S_ERR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, old_lvl: '0, new_lvl: '0,
                   div_done: 1'b0, pll_done: 1'b0, data: '0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/freq_step_seq_chk.sv
module freq_step_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_i,
    input logic [2:0] old_lvl_i,
    input logic [2:0] new_lvl_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic       reg_wr_o,
    input logic       reg_rd_o
);

    logic idle;
    logic lvl_ok;
    assign idle   = !busy_o && !done_o && !err_o;
    assign lvl_ok = (old_lvl_i <= 3'd4) && (new_lvl_i <= 3'd4);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o)); // R10
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_i && lvl_ok && (old_lvl_i != new_lvl_i)) |=> busy_o); // R10
    AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> busy_o); // R9
    AST_EQUAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_i && lvl_ok && (old_lvl_i == new_lvl_i)) |=> (done_o && !busy_o)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R11
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!busy_o && !reg_wr_o && !reg_rd_o)); // R11
    AST_BAD_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && req_i && !lvl_ok) |=> (!busy_o && !done_o)); // R12

endmodule

bind freq_step_seq freq_step_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .old_lvl_i (old_lvl_i),
    .new_lvl_i (new_lvl_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .reg_wr_o  (reg_wr_o),
    .reg_rd_o  (reg_rd_o)
);

// File: tb/freq_step_seq_bench.sv
module freq_step_seq_bench;

    localparam logic [31:0] LOCK_VAL = 32'h0000_02E8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  old_lvl = '0, new_lvl = '0;
    logic [15:0] tmo = 16'd1000;
    logic        busy, done, err, wr, rd;
    logic [2:0]  addr;
    logic [31:0] wdata, rdata;

    always #5 clk = ~clk;

    freq_step_seq u_freq_step_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req), .old_lvl_i(old_lvl),
        .new_lvl_i(new_lvl), .timeout_i(tmo), .busy_o(busy), .done_o(done),
        .err_o(err), .reg_wr_o(wr), .reg_rd_o(rd), .reg_addr_o(addr),
        .reg_wdata_o(wdata), .reg_rdata_i(rdata)
    );

    int errors = 0, checks = 0, done_cnt = 0, cyc = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---- responder model of the external registers ----
    logic [31:0] m_pll = 32'hC000_0000 | 32'h0096_0301;
    logic [31:0] m_div0 = 32'h0714_3730;
    logic [31:0] m_div1 = 32'h0000_7750;
    logic [31:0] m_lock = '0;
    logic [2:0]  m_src = 3'd1, m_src_tgt = 3'd1;
    int          src_cnt = 0, lock_cnt = 0, d0_cnt = 0, d1_cnt = 0;
    bit          stall = 1'b0;

    always_comb begin
        case (addr)
            3'd0: rdata = m_lock;
            3'd1: rdata = m_pll | ((lock_cnt == 0) ? 32'h2000_0000 : 32'h0);
            3'd2: rdata = {29'd0, m_src_tgt};
            3'd3: rdata = {29'd0, m_src};
            3'd4: rdata = m_div0;
            3'd5: rdata = 32'h8000_0000 | ((d0_cnt > 2 || stall) ? 32'h0111_1111 :
                                          (d0_cnt > 0) ? 32'h0000_1000 : 32'h0);
            3'd6: rdata = m_div1;
            default: rdata = 32'h0000_0100 | ((d1_cnt > 0) ? 32'h0000_0011 : 32'h0);
        endcase
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_cnt > 0) begin
            src_cnt <= src_cnt - 1;
            if (src_cnt == 1) m_src <= m_src_tgt;
        end
        if (lock_cnt > 0) lock_cnt <= lock_cnt - 1;
        if (d0_cnt > 0 && !stall) d0_cnt <= d0_cnt - 1;
        if (d1_cnt > 0) d1_cnt <= d1_cnt - 1;
        if (wr) begin
            case (addr)
                3'd0: m_lock <= wdata;
                3'd1: begin m_pll <= wdata & ~32'h2000_0000; lock_cnt <= 6; end
                3'd2: begin m_src_tgt <= wdata[2:0]; src_cnt <= 3; end
                3'd4: begin m_div0 <= wdata; d0_cnt <= 4; end
                3'd6: begin m_div1 <= wdata; d1_cnt <= 3; end
                default: ;
            endcase
        end
    end

    // ---- bench's own level tables, from the requirements ----
    function automatic logic [31:0] t_pll(input int l);
        int mv[5] = '{150, 250, 200, 250, 200};
        int pv[5] = '{3, 6, 6, 6, 6};
        int sv[5] = '{1, 1, 1, 2, 3};
        return (32'(mv[l]) << 16) | (32'(pv[l]) << 8) | 32'(sv[l]);
    endfunction
    function automatic logic [31:0] t_div0(input int l);
        if (l <= 1) return 32'h0714_3730;
        if (l <= 3) return 32'h0713_3730;
        return 32'h0013_1310;
    endfunction
    function automatic logic [31:0] t_div1(input int l);
        int hv[5] = '{5, 4, 3, 3, 3};
        return 32'(hv[l]) << 4;
    endfunction

    // ---- scoreboard ----
    typedef struct { logic [2:0] a; logic [31:0] v; logic [31:0] m; string tag; } item_t;
    item_t exp_q[$];

    task automatic push(input logic [2:0] a, input logic [31:0] v,
                        input logic [31:0] m, input string tag);
        item_t it;
        it.a = a; it.v = v; it.m = m; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic push_div(input int l, input string tag);
        push(3'd4, t_div0(l), 32'hFFFF_FFFF, tag);   // R6
        push(3'd6, t_div1(l), 32'h0000_0077, tag);   // R7
    endtask

    task automatic push_pll(input int o, input int n, input string tag);
        if (t_pll(o) >> 8 != t_pll(n) >> 8) begin     // R5 R8
            push(3'd2, 32'd2, 32'hFFFF_FFFF, tag);
            push(3'd0, LOCK_VAL, 32'hFFFF_FFFF, tag);
            push(3'd1, t_pll(n), 32'h03FF_3F07, tag);
            push(3'd2, 32'd1, 32'hFFFF_FFFF, tag);
        end else begin                                // R4
            push(3'd1, t_pll(n) & 32'h7, 32'h0000_0007, "R4");
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && done) done_cnt++;
        if (rst_n && wr) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "unexpected write", {29'd0, addr}, 32'hFFFF_FFFF);
            end else begin
                item_t it;
                logic [31:0] e;
                it = exp_q.pop_front();
                e = (it.m == 32'hFFFF_FFFF) ? it.v : ((rdata & ~it.m) | it.v);
                check(addr == it.a, it.tag, "write address", {29'd0, addr}, {29'd0, it.a});
                check(wdata == e, it.tag, "write data", wdata, e);
            end
        end
    end

    // ---- driver ----
    int cur = 0;

    task automatic request(input int o, input int n);
        @(negedge clk);
        req = 1'b1; old_lvl = 3'(o); new_lvl = 3'(n);
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        check(done == 1'b1, tag, "done pulse", {31'd0, done}, 32'd1);
        check(busy == 1'b0, tag, "busy low with done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        check(done == 1'b0, "R10", "done one cycle", {31'd0, done}, 32'd0);
        check(exp_q.size() == 0, tag, "all writes seen", exp_q.size(), 32'd0);
    endtask

    task automatic step(input int n, input string tag);
        if (n < cur) begin push_div(n, "R2"); push_pll(cur, n, "R2"); end
        else begin push_pll(cur, n, "R3"); push_div(n, "R3"); end
        request(cur, n);
        check(busy == 1'b1, "R10", "busy after accept", {31'd0, busy}, 32'd1);
        wait_done(tag);
        cur = n;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            check(1'b0, "R10", "watchdog expired", cyc, 32'd0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int dc;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && err == 0 && wr == 0, "R10", "reset state",
              {28'd0, busy, done, err, wr}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        step(1, "R3");   // slower, relock
        step(3, "R4");   // slower, S only
        step(1, "R4");   // faster, S only
        step(0, "R2");   // faster, relock
        step(4, "R1");   // slower, relock
        step(2, "R4");   // faster, S only

        // R9 equal indices
        dc = done_cnt;
        request(2, 2);
        check(done == 1'b1 && busy == 1'b0, "R9", "equal done next cycle",
              {30'd0, done, busy}, 32'd2);
        @(negedge clk);
        check(done == 1'b0 && done_cnt == dc + 1, "R9", "equal single done",
              done_cnt, dc + 1);

        // R10 requests while busy are ignored
        push_div(0, "R2"); push_pll(2, 0, "R2");
        request(2, 0);
        repeat (5) @(negedge clk);
        dc = done_cnt;
        request(0, 4);
        wait_done("R10");
        cur = 0;
        repeat (10) @(negedge clk);
        check(busy == 1'b0 && done_cnt == dc + 1, "R10", "busy request ignored",
              done_cnt, dc + 1);

        // R12 out-of-range index ignored
        dc = done_cnt;
        request(0, 5);
        check(busy == 1'b0 && done == 1'b0, "R12", "bad index no busy",
              {30'd0, busy, done}, 32'd0);
        repeat (5) @(negedge clk);
        check(busy == 1'b0 && done_cnt == dc, "R12", "bad index no done", done_cnt, dc);

        // R11 timeout on divider-0 poll
        tmo = 16'd20;
        stall = 1'b1;
        push_pll(0, 1, "R11");
        push(3'd4, t_div0(1), 32'hFFFF_FFFF, "R11");
        request(0, 1);
        begin
            int n = 0;
            while (!err && n < 500) begin @(negedge clk); n++; end
        end
        check(err == 1'b1, "R11", "error raised", {31'd0, err}, 32'd1);
        repeat (30) @(negedge clk);
        check(err == 1'b1 && busy == 1'b0, "R11", "error sticky, idle",
              {30'd0, err, busy}, 32'd2);
        check(exp_q.size() == 0, "R11", "writes before error", exp_q.size(), 32'd0);
        dc = done_cnt;
        request(1, 4);
        repeat (5) @(negedge clk);
        check(err == 1'b1 && done_cnt == dc, "R11", "request ignored in error",
              done_cnt, dc);

        rst_n = 1'b0;
        stall = 1'b0;
        tmo = 16'd1000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(err == 1'b0, "R11", "reset clears error", {31'd0, err}, 32'd0);
        cur = 1;
        step(4, "R3");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule